// File: doc/BRIEF.md
# Shared Parallel Bus Initiator Start Logic

This block opens a transaction on a shared, reflected-wave parallel bus with active-low control lines. Local logic holds a request (a 32-bit address and a 4-bit command) until the block accepts it. The block watches three inputs: the arbiter's active-low grant, the bus frame line and the initiator-ready line. On a clock edge where the request is pending, the grant is present and both frame and initiator-ready read high (bus idle), it takes the bus. In the next cycle it drives the address on AD, the command on C/BE# and a low level on FRAME#, and flags the acceptance to local logic.

The address phase lasts one clock. In the following clock the block stops driving AD and C/BE#, drives FRAME# high for one cycle so the line returns to its idle level, and presents PAR. PAR is even parity over the AD and C/BE# values of the previous clock. In the clock after that it releases FRAME# as well. Data phases, target decoding, retries and configuration space belong to other logic.

Top module: `bus_init_addr_phase`

## Requirements
- R1: While reset is high, and after it, until a start occurs, all four output enables are 0, FRAME# output is 1 and the accept flag is 0.
- R2: When req_valid is 1, gnt_n is 0, frame_n_in is 1 and irdy_n_in is 1 on the same rising edge while the block is idle, then in the next cycle ad_o equals the request address, cbe_o equals the request command, frame_n_o is 0, ad_oe, cbe_oe and frame_oe are 1, and req_accept is 1 for that one cycle.
- R3: The start decision uses only the grant sampled on that edge: a grant seen on an earlier edge does not allow a start on an edge where gnt_n is 1.
- R4: If frame_n_in is 0 or irdy_n_in is 0 on an edge, no start happens on that edge, even with a request and a grant.
- R5: A pending request without a grant drives nothing: all output enables stay 0.
- R6: The address phase lasts exactly one cycle. In the next cycle ad_oe and cbe_oe are 0 while frame_oe is 1 and frame_n_o is 1. In the cycle after that, frame_oe is 0.
- R7: par_oe is 1 exactly in the cycle after ad_oe is 1. In that cycle par_o makes the XOR of the previous cycle's 32 AD bits, 4 C/BE# bits and par_o equal to 0.
- R8: With a request held and the grant held, consecutive starts are spaced exactly 3 cycles apart (address, release, idle edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Local logic has a transaction pending |
| req_addr | input | 32 | Address of the pending transaction |
| req_cmd | input | 4 | Bus command of the pending transaction |
| gnt_n | input | 1 | Arbiter grant, active low |
| frame_n_in | input | 1 | Sampled bus frame line |
| irdy_n_in | input | 1 | Sampled bus initiator-ready line |
| req_accept | output | 1 | High in the address cycle; the request was taken |
| ad_o | output | 32 | Address/data value to drive |
| ad_oe | output | 1 | Drive enable for AD |
| cbe_o | output | 4 | Command/byte-enable value to drive |
| cbe_oe | output | 1 | Drive enable for C/BE# |
| frame_n_o | output | 1 | FRAME# value to drive |
| frame_oe | output | 1 | Drive enable for FRAME# |
| par_o | output | 1 | Even parity of the previous cycle's AD and C/BE# |
| par_oe | output | 1 | Drive enable for PAR |

## Verification
The bench withdraws the grant in the cycle the bus becomes idle. A design that remembered an earlier grant would start on a bus it no longer owns. It holds the grant while the frame line or the initiator-ready line is low. A design that checked only one of them would collide with another agent's transaction. Addresses with all-ones, all-zeros and walking-bit patterns reveal parity placed in the same cycle as the address, or parity that leaves out the command bits. Back-to-back requests expose a sequencer that skips or stretches the release cycle.

// File: rtl/iap_pkg.sv
package iap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_REL  = 2'd2
  } iap_state_e;
endpackage

// File: rtl/iap_start_detect.sv
module iap_start_detect (
  input  logic idle,
  input  logic req_valid,
  input  logic gnt_n,
  input  logic frame_n_in,
  input  logic irdy_n_in,
  output logic go
);
  logic bus_quiet;
  logic granted;

  // Bus counts as free only when both control lines sit at their pulled-up level.
  assign bus_quiet = frame_n_in & irdy_n_in;
  // The grant is taken from this edge alone; nothing remembers an older grant.
  assign granted   = ~gnt_n;
  assign go        = idle & req_valid & granted & bus_quiet;
endmodule

// File: rtl/iap_sequencer.sv
module iap_sequencer
  import iap_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [CBE_W-1:0] req_cmd,
  output logic             idle,
  output logic             req_accept,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe,
  output logic [CBE_W-1:0] cbe_o,
  output logic             cbe_oe,
  output logic             frame_n_o,
  output logic             frame_oe
);
  iap_state_e state;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_accept <= 1'b0;
      ad_o       <= '0;
      ad_oe      <= 1'b0;
      cbe_o      <= '0;
      cbe_oe     <= 1'b0;
      frame_n_o  <= 1'b1;
      frame_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state      <= ST_ADDR;
            ad_o       <= req_addr;
            cbe_o      <= req_cmd;
            ad_oe      <= 1'b1;
            cbe_oe     <= 1'b1;
            frame_n_o  <= 1'b0;
            frame_oe   <= 1'b1;
            req_accept <= 1'b1;
          end
        end
        ST_ADDR: begin
          // Single address clock: hand AD and C/BE# back, drive FRAME# high once.
          state      <= ST_REL;
          ad_oe      <= 1'b0;
          cbe_oe     <= 1'b0;
          frame_n_o  <= 1'b1;
          req_accept <= 1'b0;
        end
        ST_REL: begin
          state    <= ST_IDLE;
          frame_oe <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iap_parity_gen.sv
module iap_parity_gen #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_q,
  input  logic [CBE_W-1:0] cbe_q,
  input  logic             ad_oe_q,
  output logic             par_o,
  output logic             par_oe
);
  localparam int COV_W = AD_W + CBE_W;

  logic [COV_W-1:0] covered;
  assign covered = {ad_q, cbe_q};

  // Works on the already-registered bus values, so PAR trails them by one clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      par_o  <= 1'b0;
      par_oe <= 1'b0;
    end else begin
      par_o  <= ^covered;
      par_oe <= ad_oe_q;
    end
  end
endmodule

// File: rtl/bus_init_addr_phase.sv
module bus_init_addr_phase #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AD_W-1:0]  req_addr,
  input  logic [CBE_W-1:0] req_cmd,
  input  logic             gnt_n,
  input  logic             frame_n_in,
  input  logic             irdy_n_in,
  output logic             req_accept,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe,
  output logic [CBE_W-1:0] cbe_o,
  output logic             cbe_oe,
  output logic             frame_n_o,
  output logic             frame_oe,
  output logic             par_o,
  output logic             par_oe
);
  logic idle;
  logic go;

  iap_start_detect u_detect (
    .idle       (idle),
    .req_valid  (req_valid),
    .gnt_n      (gnt_n),
    .frame_n_in (frame_n_in),
    .irdy_n_in  (irdy_n_in),
    .go         (go)
  );

  iap_sequencer #(.AD_W(AD_W), .CBE_W(CBE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .req_addr   (req_addr),
    .req_cmd    (req_cmd),
    .idle       (idle),
    .req_accept (req_accept),
    .ad_o       (ad_o),
    .ad_oe      (ad_oe),
    .cbe_o      (cbe_o),
    .cbe_oe     (cbe_oe),
    .frame_n_o  (frame_n_o),
    .frame_oe   (frame_oe)
  );

  iap_parity_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
    .clk     (clk),
    .rst     (rst),
    .ad_q    (ad_o),
    .cbe_q   (cbe_o),
    .ad_oe_q (ad_oe),
    .par_o   (par_o),
    .par_oe  (par_oe)
  );
endmodule

// File: rtl/bus_init_addr_phase_chk.sv
module bus_init_addr_phase_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             gnt_n,
  input logic             frame_n_in,
  input logic             irdy_n_in,
  input logic             req_accept,
  input logic [AD_W-1:0]  ad_o,
  input logic             ad_oe,
  input logic [CBE_W-1:0] cbe_o,
  input logic             cbe_oe,
  input logic             frame_n_o,
  input logic             frame_oe,
  input logic             par_o,
  input logic             par_oe
);
  a_r2_start_conditions: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(req_valid && frame_n_in && irdy_n_in));

  a_r3_grant_same_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(!gnt_n));

  a_r2_accept_with_drive: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> (ad_oe && cbe_oe && frame_oe && !frame_n_o));

  a_r6_single_addr_cycle: assert property (@(posedge clk) disable iff (rst)
    ad_oe |=> !ad_oe);

  a_r6_release_high: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe) |-> (frame_oe && frame_n_o && !cbe_oe));

  a_r1_idle_frame_high: assert property (@(posedge clk) disable iff (rst)
    !frame_oe |-> frame_n_o);

  a_r7_par_follows: assert property (@(posedge clk) disable iff (rst)
    ad_oe |=> par_oe);

  a_r7_even_parity: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> ((^{$past(ad_o), $past(cbe_o)}) ^ par_o) == 1'b0);
endmodule

bind bus_init_addr_phase bus_init_addr_phase_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (.*);

// File: tb/tb_bus_init_addr_phase.sv
`timescale 1ns/1ps
module tb_bus_init_addr_phase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic        gnt_n = 1'b1;
  logic        ext_frame_n = 1'b1;
  logic        ext_irdy_n = 1'b1;
  logic        frame_n_in, irdy_n_in;
  logic        req_accept, ad_oe, cbe_oe, frame_n_o, frame_oe, par_o, par_oe;
  logic [31:0] ad_o;
  logic [3:0]  cbe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  // Shared-line model: our FRAME# wins when enabled, otherwise the other agent / pull-up.
  assign frame_n_in = frame_oe ? frame_n_o : ext_frame_n;
  assign irdy_n_in  = ext_irdy_n;

  bus_init_addr_phase dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase counter 0 idle, 1 address, 2 release.
  int          m_phase = 0;
  logic [31:0] m_addr = '0;
  logic [3:0]  m_cmd = '0;
  always @(posedge clk) begin
    if (rst) m_phase = 0;
    else if (m_phase == 1) m_phase = 2;
    else if (m_phase == 2) m_phase = 0;
    else if (req_valid && !gnt_n && frame_n_in && irdy_n_in) begin
      m_phase = 1;
      m_addr  = req_addr;
      m_cmd   = req_cmd;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string tg;
      tg = (m_phase == 1) ? "R2" : (m_phase == 2) ? "R6" : "R5";
      chk(ad_oe == (m_phase == 1), tg, ad_oe, m_phase == 1);
      chk(cbe_oe == (m_phase == 1), tg, cbe_oe, m_phase == 1);
      chk(frame_oe == (m_phase != 0), tg, frame_oe, m_phase != 0);
      chk(frame_n_o == (m_phase != 1), tg, frame_n_o, m_phase != 1);
      chk(req_accept == (m_phase == 1), tg, req_accept, m_phase == 1);
      if (m_phase == 1) begin
        chk(ad_o == m_addr, "R2", ad_o, m_addr);
        chk(cbe_o == m_cmd, "R2", cbe_o, m_cmd);
      end
      chk(par_oe == (m_phase == 2), "R7", par_oe, m_phase == 2);
      if (m_phase == 2) chk(par_o == ^{m_addr, m_cmd}, "R7", par_o, ^{m_addr, m_cmd});
    end
  end

  task automatic wait_accept(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!req_accept && cycles < 40);
  endtask

  task automatic one_txn(input logic [31:0] a, input logic [3:0] c);
    int cy;
    req_valid = 1'b1; req_addr = a; req_cmd = c; gnt_n = 1'b0;
    wait_accept(cy);
    chk(req_accept === 1'b1, "R2", req_accept, 1);
    req_valid = 1'b0; gnt_n = 1'b1;
    @(negedge clk);
    chk(par_oe === 1'b1 && ((^{a, c}) ^ par_o) == 1'b0, "R7", {par_oe, par_o}, 2'b10);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cy;
    repeat (4) @(negedge clk);
    // R1: reset values while reset is high
    chk({ad_oe, cbe_oe, frame_oe, par_oe, req_accept} == 5'b0, "R1", {ad_oe, cbe_oe, frame_oe, par_oe, req_accept}, 0);
    chk(frame_n_o == 1'b1, "R1", frame_n_o, 1);
    rst = 1'b0;
    cmp_en = 1'b1;
    repeat (2) @(negedge clk);
    chk({ad_oe, cbe_oe, frame_oe, par_oe} == 4'b0, "R1", {ad_oe, cbe_oe, frame_oe, par_oe}, 0);

    // R2 / R7: basic transactions with varied patterns
    one_txn(32'h0000_0000, 4'h0);
    one_txn(32'hFFFF_FFFF, 4'hF);
    one_txn(32'h8000_0001, 4'h6);
    for (int i = 0; i < 32; i += 5) one_txn(32'h1 << i, 4'(i));
    one_txn(32'hDEAD_BEEF, 4'h7);

    // R5: request pending, no grant
    req_valid = 1'b1; req_addr = 32'h1234_5678; req_cmd = 4'h3; gnt_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk({ad_oe, cbe_oe, frame_oe, par_oe} == 4'b0, "R5", {ad_oe, cbe_oe, frame_oe, par_oe}, 0);
    end

    // R3: grant while busy, then withdrawn on the idle edge
    gnt_n = 1'b0; ext_frame_n = 1'b0;
    @(negedge clk);
    gnt_n = 1'b1; ext_frame_n = 1'b1;
    @(negedge clk);
    chk(req_accept == 1'b0 && ad_oe == 1'b0, "R3", {req_accept, ad_oe}, 0);
    @(negedge clk);
    chk(ad_oe == 1'b0, "R3", ad_oe, 0);
    gnt_n = 1'b0;
    @(negedge clk);
    chk(req_accept == 1'b1, "R3", req_accept, 1);
    req_valid = 1'b0; gnt_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4: busy bus blocks start, via either line
    req_valid = 1'b1; req_addr = 32'h0F0F_0F0F; gnt_n = 1'b0; ext_frame_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_accept == 1'b0, "R4", req_accept, 0);
    end
    ext_frame_n = 1'b1; ext_irdy_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_accept == 1'b0, "R4", req_accept, 0);
    end
    ext_irdy_n = 1'b1;
    @(negedge clk);
    chk(req_accept == 1'b1, "R4", req_accept, 1);
    req_valid = 1'b0; gnt_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: back-to-back spacing with request and grant held
    req_valid = 1'b1; req_addr = 32'hA5A5_0000; req_cmd = 4'hB; gnt_n = 1'b0;
    wait_accept(cy);
    for (int k = 0; k < 3; k++) begin
      req_addr = req_addr + 32'h10;
      wait_accept(cy);
      chk(cy == 3, "R8", cy, 3);
    end
    req_valid = 1'b0; gnt_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule